// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block governs the low-power stop state of a small microcontroller core. When the core requests stop, the block gates the main clock off and records the control settings in force at that moment. It also decides whether the slow internal RC clock keeps the watchdog counter alive while stopped. The block then waits for something to end the stop state: a hardware reset, any external interrupt line, or a watchdog event when the RC domain is kept running.

An interrupt-type wake-up does not give the clock back at once. An 8-bit stabilisation counter starts from zero and advances on ticks from a prescaler whose ratio was latched at stop entry. Only its overflow re-enables the core clock. At that moment the block emits exactly one of three single-cycle outcomes: resume after the stop, an interrupt request with a cause code, or an internal reset. A hardware reset, or a watchdog event with watchdog reset enabled, takes a fixed-length reset wait instead. That wait ends in an internal reset pulse and restores the latched control settings to their defaults.

Top module: `stop_wake_seq`

## Requirements
- R1: After rst_n is released, core_clk_en and rc_clk_en are 1, and sleeping, resume_pulse, irq_req and internal_rst are 0.
- R2: A stop_req sampled while running makes sleeping 1 and core_clk_en 0 from the next cycle on.
- R3: When the stop was entered with ctl_rc_keep = 0, rc_clk_en is 0 while sleeping, and wdt_event has no effect; the block stays asleep until an external interrupt or reset.
- R4: After an interrupt-type wake sampled at edge W, core_clk_en stays 0 and returns to 1 at edge W + 256 * 2^(p+1). Here p is the 3-bit ctl_presc value latched at stop entry; later changes to ctl_presc do not matter.
- R5: If gie is 0 at release, the outcome is a single resume_pulse and no irq_req.
- R6: An external wake (any bit of ext_irq) with gie = 1 gives irq_req with irq_cause = 2'b01.
- R7: A watchdog wake with ctl_wdt_rst = 0 gives irq_req with irq_cause = 2'b10 when gie = 1 and ctl_wdt_ie = 1. Otherwise it gives resume_pulse.
- R8: A watchdog event while stopped with ctl_rc_keep = 1 and ctl_wdt_rst = 1 skips stabilisation. It holds core_clk_en at 0 for RST_CYCLES cycles and then pulses internal_rst instead of any interrupt.
- R9: hw_reset in any state starts the reset wait, so internal_rst pulses at edge R + RST_CYCLES. It wins over an external interrupt in the same cycle, and no interrupt or resume follows.
- R10: stop_req is ignored outside the running state: during stabilisation or reset wait it does not lead back into stop.
- R11: resume_pulse, irq_req and internal_rst are each one cycle long and never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hw_reset | input | 1 | Hardware reset event from the reset pin |
| stop_req | input | 1 | Stop request from the core |
| ext_irq | input | N_EXT | External interrupt request lines |
| wdt_event | input | 1 | Watchdog event from the RC domain |
| gie | input | 1 | Global interrupt enable flag of the core |
| ctl_rc_keep | input | 1 | Keep RC clock and watchdog running in stop |
| ctl_wdt_rst | input | 1 | Watchdog event causes reset |
| ctl_wdt_ie | input | 1 | Watchdog interrupt enable |
| ctl_presc | input | 3 | Prescaler select, ratio 2^(n+1) |
| core_clk_en | output | 1 | Main clock enable to the core |
| rc_clk_en | output | 1 | RC domain clock enable |
| sleeping | output | 1 | High while in the stop state |
| resume_pulse | output | 1 | Resume after stop, one cycle |
| irq_req | output | 1 | Interrupt vector request, one cycle |
| irq_cause | output | 2 | Cause with irq_req: 01 external, 10 watchdog |
| internal_rst | output | 1 | Internal reset pulse, one cycle |

## Verification
The bench builds the block with RST_CYCLES = 40 and N_EXT = 2. With the full 64 ms reset wait, every reset path would take a quarter of a million cycles. The shortened count lets hardware resets, watchdog resets and a reset that collides with an interrupt all be run to their exact release edge. The stabilisation counter keeps its real 8-bit width, and prescaler selects 0, 1 and 2 are used, so the bench checks the real 512, 1024 and 2048 cycle windows. Using bit 1 of a two-line interrupt vector shows that any line can wake the block.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_STAB = 2'd2,
    ST_RSTW = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_EXT  = 2'b01,
    CAUSE_WDT  = 2'b10
  } wake_cause_t;

  typedef enum logic [1:0] {
    EXIT_RESUME = 2'd0,
    EXIT_VECTOR = 2'd1,
    EXIT_RESET  = 2'd2
  } exit_kind_t;

  typedef struct packed {
    logic       rc_keep;
    logic       wdt_rst;
    logic       wdt_ie;
    logic [2:0] presc;
  } stop_ctl_t;

  localparam stop_ctl_t CTL_DEFAULT = '{rc_keep: 1'b0, wdt_rst: 1'b0,
                                        wdt_ie: 1'b0, presc: 3'd0};

  // Cycles per prescaled tick for a select value.
  function automatic int unsigned tick_ratio(input logic [2:0] sel);
    return 32'd2 << sel;
  endfunction

  // Outcome taken when stabilisation ends.
  function automatic exit_kind_t pick_exit(input wake_cause_t cause,
                                           input logic gie_i,
                                           input logic wdt_ie_i);
    if (!gie_i) return EXIT_RESUME;
    if (cause == CAUSE_EXT) return EXIT_VECTOR;
    if (cause == CAUSE_WDT && wdt_ie_i) return EXIT_VECTOR;
    return EXIT_RESUME;
  endfunction

endpackage

// File: rtl/stop_wake_presc.sv
module stop_wake_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PW = (1 << SEL_W) + 1;

  logic [PW-1:0] cnt;
  logic [PW-1:0] lim;

  assign lim  = (PW'(2) << sel) - PW'(1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (run)    cnt <= tick ? '0 : cnt + PW'(1);
  end
endmodule

// File: rtl/stop_wake_stab.sv
module stop_wake_stab #(
  parameter int STAB_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic ovf
);
  logic [STAB_W-1:0] cnt;

  assign ovf = tick && (cnt == {STAB_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + STAB_W'(1);
  end
endmodule

// File: rtl/stop_wake_rstw.sv
module stop_wake_rstw #(
  parameter int RST_CYCLES = 256000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int CW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(RST_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run && !done) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import stop_wake_pkg::*;
#(
  parameter int N_EXT      = 4,
  parameter int STAB_W     = 8,
  parameter int SEL_W      = 3,
  parameter int RST_CYCLES = 256000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_reset,
  input  logic             stop_req,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             wdt_event,
  input  logic             gie,
  input  logic             ctl_rc_keep,
  input  logic             ctl_wdt_rst,
  input  logic             ctl_wdt_ie,
  input  logic [2:0]       ctl_presc,
  output logic             core_clk_en,
  output logic             rc_clk_en,
  output logic             sleeping,
  output logic             resume_pulse,
  output logic             irq_req,
  output logic [1:0]       irq_cause,
  output logic             internal_rst
);

  seq_state_t  state, state_nx;
  stop_ctl_t   ctl_q, ctl_nx, ctl_in;
  wake_cause_t cause_q, cause_nx;
  exit_kind_t  exit_sel;

  logic resume_nx, irq_nx, irst_nx;
  logic [1:0] irq_cause_q;

  // Named internal events
  logic ev_stop_accept;
  logic ev_ext_wake;
  logic ev_wdt_seen;
  logic ev_wdt_reset;
  logic ev_tick;
  logic ev_ovf;
  logic ev_rst_done;

  assign ctl_in = '{rc_keep: ctl_rc_keep, wdt_rst: ctl_wdt_rst,
                    wdt_ie: ctl_wdt_ie, presc: ctl_presc};

  assign ev_stop_accept = (state == ST_RUN) && stop_req && !hw_reset;
  assign ev_ext_wake    = (state == ST_STOP) && (|ext_irq);
  assign ev_wdt_seen    = (state == ST_STOP) && wdt_event && ctl_q.rc_keep;
  assign ev_wdt_reset   = ev_wdt_seen && ctl_q.wdt_rst;

  stop_wake_presc #(.SEL_W(SEL_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state != ST_STAB),
    .run   (state == ST_STAB),
    .sel   (ctl_q.presc[SEL_W-1:0]),
    .tick  (ev_tick)
  );

  stop_wake_stab #(.STAB_W(STAB_W)) u_stab (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state != ST_STAB),
    .tick  (ev_tick),
    .ovf   (ev_ovf)
  );

  stop_wake_rstw #(.RST_CYCLES(RST_CYCLES)) u_rstw (
    .clk   (clk),
    .rst_n (rst_n),
    .clear ((state != ST_RSTW) || hw_reset),
    .run   (state == ST_RSTW),
    .done  (ev_rst_done)
  );

  assign exit_sel = pick_exit(cause_q, gie, ctl_q.wdt_ie);

  always_comb begin
    state_nx  = state;
    ctl_nx    = ctl_q;
    cause_nx  = cause_q;
    resume_nx = 1'b0;
    irq_nx    = 1'b0;
    irst_nx   = 1'b0;
    if (hw_reset) begin
      state_nx = ST_RSTW;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (ev_stop_accept) begin
            state_nx = ST_STOP;
            ctl_nx   = ctl_in;
            cause_nx = CAUSE_NONE;
          end
        end
        ST_STOP: begin
          if (ev_wdt_reset) begin
            state_nx = ST_RSTW;
          end else if (ev_ext_wake) begin
            state_nx = ST_STAB;
            cause_nx = CAUSE_EXT;
          end else if (ev_wdt_seen) begin
            state_nx = ST_STAB;
            cause_nx = CAUSE_WDT;
          end
        end
        ST_STAB: begin
          if (ev_ovf) begin
            state_nx  = ST_RUN;
            resume_nx = (exit_sel == EXIT_RESUME);
            irq_nx    = (exit_sel == EXIT_VECTOR);
          end
        end
        ST_RSTW: begin
          if (ev_rst_done) begin
            state_nx = ST_RUN;
            irst_nx  = 1'b1;
            ctl_nx   = CTL_DEFAULT;
            cause_nx = CAUSE_NONE;
          end
        end
        default: state_nx = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      ctl_q        <= CTL_DEFAULT;
      cause_q      <= CAUSE_NONE;
      resume_pulse <= 1'b0;
      irq_req      <= 1'b0;
      irq_cause_q  <= 2'b00;
      internal_rst <= 1'b0;
    end else begin
      state        <= state_nx;
      ctl_q        <= ctl_nx;
      cause_q      <= cause_nx;
      resume_pulse <= resume_nx;
      irq_req      <= irq_nx;
      irq_cause_q  <= irq_nx ? cause_q : 2'b00;
      internal_rst <= irst_nx;
    end
  end

  assign irq_cause   = irq_cause_q;
  assign core_clk_en = (state == ST_RUN);
  assign sleeping    = (state == ST_STOP);
  assign rc_clk_en   = !((state == ST_STOP) && !ctl_q.rc_keep);

endmodule

// File: rtl/stop_wake_seq_chk.sv
module stop_wake_seq_chk #(
  parameter int N_EXT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_reset,
  input logic             stop_req,
  input logic [N_EXT-1:0] ext_irq,
  input logic             wdt_event,
  input logic             core_clk_en,
  input logic             rc_clk_en,
  input logic             sleeping,
  input logic             resume_pulse,
  input logic             irq_req,
  input logic [1:0]       irq_cause,
  input logic             internal_rst,
  input logic             ev_ovf,
  input logic             ev_rst_done
);

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_pulse, irq_req, internal_rst}));

  p_resume_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  p_rst_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    internal_rst |=> !internal_rst);

  p_sleep_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> !core_clk_en);

  p_stop_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && stop_req && !hw_reset) |=> (sleeping && !core_clk_en));

  p_rc_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !rc_clk_en && wdt_event && (ext_irq == '0) && !hw_reset)
      |=> sleeping);

  p_cause_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_cause == 2'b01 || irq_cause == 2'b10));

  p_ovf_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovf && !hw_reset) |=> (core_clk_en && (resume_pulse || irq_req)));

  p_clk_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> (resume_pulse || irq_req || internal_rst));

  p_hw_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset |=> (!core_clk_en && !sleeping && !irq_req && !resume_pulse));

  p_rst_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rst_done && !hw_reset) |=> internal_rst);

  p_no_restop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && !sleeping && stop_req) |=> !sleeping);

endmodule

bind stop_wake_seq stop_wake_seq_chk #(.N_EXT(N_EXT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hw_reset     (hw_reset),
  .stop_req     (stop_req),
  .ext_irq      (ext_irq),
  .wdt_event    (wdt_event),
  .core_clk_en  (core_clk_en),
  .rc_clk_en    (rc_clk_en),
  .sleeping     (sleeping),
  .resume_pulse (resume_pulse),
  .irq_req      (irq_req),
  .irq_cause    (irq_cause),
  .internal_rst (internal_rst),
  .ev_ovf       (ev_ovf),
  .ev_rst_done  (ev_rst_done)
);

// File: tb/stop_wake_seq_bench.sv
module stop_wake_seq_bench;

  localparam int N_EXT      = 2;
  localparam int RST_CYCLES = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_reset = 1'b0, stop_req = 1'b0, wdt_event = 1'b0, gie = 1'b0;
  logic [N_EXT-1:0] ext_irq = '0;
  logic ctl_rc_keep = 1'b0, ctl_wdt_rst = 1'b0, ctl_wdt_ie = 1'b0;
  logic [2:0] ctl_presc = 3'd0;
  logic core_clk_en, rc_clk_en, sleeping, resume_pulse, irq_req, internal_rst;
  logic [1:0] irq_cause;

  stop_wake_seq #(.N_EXT(N_EXT), .RST_CYCLES(RST_CYCLES)) u_stop_wake_seq (
    .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .stop_req(stop_req),
    .ext_irq(ext_irq), .wdt_event(wdt_event), .gie(gie),
    .ctl_rc_keep(ctl_rc_keep), .ctl_wdt_rst(ctl_wdt_rst),
    .ctl_wdt_ie(ctl_wdt_ie), .ctl_presc(ctl_presc),
    .core_clk_en(core_clk_en), .rc_clk_en(rc_clk_en), .sleeping(sleeping),
    .resume_pulse(resume_pulse), .irq_req(irq_req), .irq_cause(irq_cause),
    .internal_rst(internal_rst)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  longint cyc = 0;
  longint wake_at = 0;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // kind: 0 resume, 1 interrupt, 2 internal reset
  typedef struct {
    int     kind;
    int     cause;
    longint at;
    string  req;
  } exp_t;
  exp_t sb[$];

  function automatic longint stab_len(input int sel);
    return 64'd256 * (64'd1 << (sel + 1));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int cause, input longint at,
                           input string req);
    exp_t e;
    e.kind = kind; e.cause = cause; e.at = at; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: every outcome pulse is popped and compared.
  always @(negedge clk) begin
    if (rst_n && (resume_pulse || irq_req || internal_rst)) begin
      int kind;
      kind = internal_rst ? 2 : (irq_req ? 1 : 0);
      if (sb.size() == 0) begin
        check("R11 unexpected outcome kind", kind, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " kind"}, kind, e.kind);
        check({e.req, " cycle"}, cyc, e.at);
        if (kind == 1) check({e.req, " cause"}, irq_cause, e.cause);
        check("R11 one-hot", int'(resume_pulse) + int'(irq_req) + int'(internal_rst), 1);
      end
    end
  end

  task automatic enter_stop(input logic rc, input logic wrst, input logic wie,
                            input logic [2:0] sel);
    ctl_rc_keep = rc; ctl_wdt_rst = wrst; ctl_wdt_ie = wie; ctl_presc = sel;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R2 sleeping", sleeping, 1);
    check("R2 core_clk_en", core_clk_en, 0);
  endtask

  task automatic pulse_ext(input logic [N_EXT-1:0] v);
    ext_irq = v; wake_at = cyc + 1;
    @(negedge clk);
    ext_irq = '0;
  endtask

  task automatic pulse_wdt();
    wdt_event = 1'b1; wake_at = cyc + 1;
    @(negedge clk);
    wdt_event = 1'b0;
  endtask

  task automatic drain(input string req);
    int t;
    t = 0;
    while (sb.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check({req, " outcome seen"}, sb.size(), 0);
    sb.delete();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 core_clk_en", core_clk_en, 1);
    check("R1 rc_clk_en", rc_clk_en, 1);
    check("R1 sleeping", sleeping, 0);
    check("R1 pulses", {resume_pulse, irq_req, internal_rst}, 0);

    // R4 R5: external wake, gie=0, sel=0; later presc change ignored
    gie = 1'b0;
    enter_stop(1'b1, 1'b0, 1'b0, 3'd0);
    ctl_presc = 3'd3;
    repeat (3) @(negedge clk);
    pulse_ext(2'b10);
    expect_ev(0, 0, wake_at + stab_len(0), "R4 R5 resume sel0");
    repeat (300) @(negedge clk);
    check("R4 clock held mid-stab", core_clk_en, 0);
    drain("R5");
    check("R4 clock back", core_clk_en, 1);

    // R6: external wake with gie=1, sel=1
    gie = 1'b1;
    enter_stop(1'b1, 1'b0, 1'b0, 3'd1);
    pulse_ext(2'b01);
    expect_ev(1, 1, wake_at + stab_len(1), "R6 ext vector");
    drain("R6");

    // R7 + R10: watchdog wake with interrupt enable, stop_req in stab ignored
    enter_stop(1'b1, 1'b0, 1'b1, 3'd0);
    check("R3 rc kept", rc_clk_en, 1);
    pulse_wdt();
    expect_ev(1, 2, wake_at + stab_len(0), "R7 wdt vector");
    repeat (100) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R10 no re-stop in stab", sleeping, 0);
    drain("R7");
    check("R10 running after exit", sleeping, 0);

    // R7: watchdog wake without interrupt enable -> resume
    enter_stop(1'b1, 1'b0, 1'b0, 3'd0);
    pulse_wdt();
    expect_ev(0, 0, wake_at + stab_len(0), "R7 wdt resume");
    drain("R7b");

    // R3: RC domain halted, watchdog event ignored
    gie = 1'b0;
    enter_stop(1'b0, 1'b0, 1'b1, 3'd0);
    check("R3 rc halted", rc_clk_en, 0);
    pulse_wdt();
    repeat (10) @(negedge clk);
    check("R3 still sleeping", sleeping, 1);
    pulse_ext(2'b01);
    expect_ev(0, 0, wake_at + stab_len(0), "R3 ext after ignored wdt");
    drain("R3");

    // R8: watchdog reset path
    gie = 1'b1;
    enter_stop(1'b1, 1'b1, 1'b1, 3'd2);
    pulse_wdt();
    expect_ev(2, 0, wake_at + RST_CYCLES, "R8 wdt reset");
    repeat (20) @(negedge clk);
    check("R8 clock held", core_clk_en, 0);
    drain("R8");

    // R9: reset and interrupt in the same cycle while stopped
    enter_stop(1'b1, 1'b0, 1'b1, 3'd0);
    hw_reset = 1'b1;
    pulse_ext(2'b11);
    hw_reset = 1'b0;
    expect_ev(2, 0, wake_at + RST_CYCLES, "R9 reset beats irq");
    drain("R9");
    repeat (600) @(negedge clk);
    check("R9 no late outcome queue", sb.size(), 0);

    // R9 + R10: reset while running, stop_req during wait ignored
    hw_reset = 1'b1; wake_at = cyc + 1;
    @(negedge clk);
    hw_reset = 1'b0;
    expect_ev(2, 0, wake_at + RST_CYCLES, "R9 run reset");
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R10 no stop in reset wait", sleeping, 0);
    drain("R9b");
    check("R10 awake after reset", sleeping, 0);

    // R4: longer window, sel=2
    gie = 1'b0;
    enter_stop(1'b1, 1'b0, 1'b0, 3'd2);
    pulse_ext(2'b01);
    expect_ev(0, 0, wake_at + stab_len(2), "R4 sel2 window");
    drain("R4");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule